// File: doc/BRIEF.md
# Three-Stream Wide-Word Memory Streamer

This block sits between a single-ported synchronous SRAM with a wide data word and a pixel-update engine that works on narrow lanes. Two streams are read from memory: current node values and speed values. One stream is written back: freshly computed node values. Each stream has its own word FIFO and its own address ring. A memory word carries several lanes, and each lane is one pair of 12-bit values. The block splits words into lanes on the read side and gathers lanes into words on the write side as the data flows.

One memory access is issued per cycle at most. A rotating arbiter shares the cycles between the two read streams and the write stream. It passes over a read stream whose FIFO has no room for the word in flight, and it passes over the write stream while there is no complete word to store. The engine is allowed to run only when it can take a node pair and a speed pair together and when there is room for its results. A sleep input holds the engine between pairs. A one-cycle interrupt marks each completed frame of results.

Top module: `wide_mem_streamer`

## Requirements
- R1: A memory word holds LANES = WORD_W/LANE_W lanes. Lane j sits at bits [j*LANE_W +: LANE_W]. Lane 0 is handed to the engine first and is also the first result gathered into a written word.
- R2: Node words are read from X_BASE+k, speed words from F_BASE+k, and result words are written to W_BASE+k. Each stream's k advances by one per access to that stream.
- R3: Each stream's k wraps from FRAME_WORDS-1 back to 0, so its addresses form a circular buffer.
- R4: At most one of mem_re and mem_we is high in any cycle. Read data is taken from mem_rdata one cycle after mem_re.
- R5: Access slots rotate in the order node-read, speed-read, write. A stream takes a slot only if it is eligible, and the rotation continues from the last stream granted. Just after reset the first four accesses alternate node, speed, node, speed.
- R6: calc_en is low while sleep_req is high, while either input FIFO is empty, or while the result FIFO holds at least OUT_DEPTH-HEADROOM words.
- R7: In each cycle with calc_en high, the engine takes one node pair and one speed pair, in address order with no gap or repeat. Outside those cycles x_lane and f_lane hold steady while the input FIFOs are not empty.
- R8: frame_irq pulses high for one cycle, in the cycle after the FRAME_PAIRS-th result pair (FRAME_PAIRS = FRAME_WORDS*LANES) of a frame is accepted on xn_valid. Counting then restarts at zero.
- R9: While sleep_req is high, no pair is consumed. After release, consumption resumes at the next pair and nothing is lost.
- R10: While rst is high, mem_re, mem_we, calc_en and frame_irq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_re | output | 1 | SRAM read strobe |
| mem_we | output | 1 | SRAM write strobe |
| mem_wdata | output | WORD_W | SRAM write data |
| mem_rdata | input | WORD_W | SRAM read data, valid one cycle after mem_re |
| x_lane | output | LANE_W | Current node pair to the engine |
| f_lane | output | LANE_W | Current speed pair to the engine |
| calc_en | output | 1 | Engine consumes x_lane and f_lane this cycle |
| xn_valid | input | 1 | Engine presents a result pair |
| xn_lane | input | LANE_W | Result pair from the engine |
| sleep_req | input | 1 | Hold the engine between pairs |
| frame_irq | output | 1 | One-cycle pulse at frame completion |

## Verification
Some properties are checked by the embedded assertions on every cycle. These are: read and write strobes never both high, no FIFO overflow or underflow, every address step and ring wrap, a stream granted twice in a row only when it was the only eligible one, lanes held while the engine is stalled, and an interrupt never lasting two cycles. Other properties can only be shown by the bench's scenarios, which compare against a memory model and an engine model. These are: the lane order inside words, the exact data sequence across ring wraps and sleep intervals, the write contents, the start-up alternation of slots, and the placement of each interrupt relative to the last pair of a frame.

// File: rtl/wms_pkg.sv
package wms_pkg;
   typedef enum logic [1:0] {
      SLOT_RX = 2'd0,
      SLOT_RF = 2'd1,
      SLOT_WX = 2'd2
   } slot_e;
   localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/wms_fifo.sv
module wms_fifo #(
   parameter int W     = 72,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("wms_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) store[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: ;
         endcase
      end
   end

   assign dout  = store[rp];
   assign full  = (count == (AW+1)'(DEPTH));
   assign empty = (count == '0);

   // R6
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);
   // R7
   fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);
endmodule

// File: rtl/wms_ring_addr.sv
module wms_ring_addr #(
   parameter int AW   = 8,
   parameter int BASE = 0,
   parameter int SPAN = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] FIRST = AW'(BASE);
   localparam logic [AW-1:0] LAST  = AW'(BASE + SPAN - 1);

   generate
      if (SPAN < 1 || BASE + SPAN > (1 << AW)) begin : g_bad_span
         $error("wms_ring_addr: ring does not fit in the address space");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       addr <= FIRST;
      else if (step) addr <= (addr == LAST) ? FIRST : addr + 1'b1;
   end

   // R3
   ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (step && addr == LAST) |=> addr == FIRST);
   // R2
   ring_step_chk: assert property (@(posedge clk) disable iff (rst)
      (step && addr != LAST) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/wms_rr_arb.sv
module wms_rr_arb #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] elig,
   output logic [N-1:0] gnt
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] last;

   always_comb begin
      logic found;
      gnt   = '0;
      found = 1'b0;
      for (int k = 1; k <= N; k++) begin
         int idx;
         idx = (int'(last) + k) % N;
         if (!found && elig[idx]) begin
            gnt[idx] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) last <= IW'(N - 1);
      else begin
         for (int i = 0; i < N; i++) begin
            if (gnt[i]) last <= IW'(i);
         end
      end
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_fair
         // R5
         rr_fair_chk: assert property (@(posedge clk) disable iff (rst)
            gnt[i] ##1 gnt[i] |-> $countones(elig) == 1);
      end
   endgenerate
endmodule

// File: rtl/wide_mem_streamer.sv
module wide_mem_streamer
   import wms_pkg::*;
#(
   parameter int LANE_W      = 24,
   parameter int WORD_W      = 72,
   parameter int ADDR_W      = 8,
   parameter int FRAME_WORDS = 8,
   parameter int X_BASE      = 0,
   parameter int F_BASE      = 64,
   parameter int W_BASE      = 128,
   parameter int IN_DEPTH    = 4,
   parameter int OUT_DEPTH   = 4,
   parameter int HEADROOM    = 2
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [LANE_W-1:0] x_lane,
   output logic [LANE_W-1:0] f_lane,
   output logic              calc_en,
   input  logic              xn_valid,
   input  logic [LANE_W-1:0] xn_lane,
   input  logic              sleep_req,
   output logic              frame_irq
);
   localparam int LANES       = WORD_W / LANE_W;
   localparam int LIW         = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int FRAME_PAIRS = FRAME_WORDS * LANES;
   localparam int FCW         = (FRAME_PAIRS > 1) ? $clog2(FRAME_PAIRS) : 1;
   localparam int ICW         = $clog2(IN_DEPTH) + 1;
   localparam int OCW         = $clog2(OUT_DEPTH) + 1;

   generate
      if (WORD_W % LANE_W != 0 || LANES < 2) begin : g_bad_lanes
         $error("wide_mem_streamer: WORD_W must hold a whole number (>=2) of lanes");
      end
      if (HEADROOM < 1 || HEADROOM >= OUT_DEPTH) begin : g_bad_headroom
         $error("wide_mem_streamer: HEADROOM must lie in 1..OUT_DEPTH-1");
      end
      if (FRAME_WORDS < 1) begin : g_bad_frame
         $error("wide_mem_streamer: FRAME_WORDS must be positive");
      end
   endgenerate

   // ---------------- arbitration ----------------
   logic [NUM_SLOTS-1:0] elig, gnt;
   logic [1:0]           rd_pend;

   wms_rr_arb #(.N(NUM_SLOTS)) u_arb (
      .clk(clk), .rst(rst), .elig(elig), .gnt(gnt)
   );

   always_ff @(posedge clk) begin
      if (rst) rd_pend <= '0;
      else     rd_pend <= {gnt[SLOT_RF], gnt[SLOT_RX]};
   end

   // ---------------- read streams ----------------
   logic [WORD_W-1:0] in_head [2];
   logic [ICW-1:0]    in_cnt  [2];
   logic [ADDR_W-1:0] rd_addr [2];
   logic [1:0]        in_full, in_empty, in_pop;
   logic [LIW-1:0]    li;

   generate
      for (genvar s = 0; s < 2; s++) begin : g_rd
         wms_ring_addr #(
            .AW(ADDR_W), .BASE((s == 0) ? X_BASE : F_BASE), .SPAN(FRAME_WORDS)
         ) u_ring (
            .clk(clk), .rst(rst), .step(gnt[s]), .addr(rd_addr[s])
         );
         wms_fifo #(.W(WORD_W), .DEPTH(IN_DEPTH)) u_fifo (
            .clk(clk), .rst(rst), .push(rd_pend[s]), .din(mem_rdata),
            .pop(in_pop[s]), .dout(in_head[s]), .count(in_cnt[s]),
            .full(in_full[s]), .empty(in_empty[s])
         );
         assign elig[s] = !rst && !in_full[s] &&
                          (int'(in_cnt[s]) + int'(rd_pend[s]) < IN_DEPTH);
         assign in_pop[s] = calc_en && (li == LIW'(LANES - 1));
      end
   endgenerate

   // ---------------- write stream ----------------
   logic [WORD_W-1:0] out_head, pk_word, pk_next;
   logic [OCW-1:0]    out_cnt;
   logic              out_full, out_empty, out_push;
   logic [LIW-1:0]    pk_idx;
   logic [ADDR_W-1:0] wr_addr;

   wms_ring_addr #(.AW(ADDR_W), .BASE(W_BASE), .SPAN(FRAME_WORDS)) u_wring (
      .clk(clk), .rst(rst), .step(gnt[SLOT_WX]), .addr(wr_addr)
   );

   always_comb begin
      pk_next = pk_word;
      pk_next[int'(pk_idx)*LANE_W +: LANE_W] = xn_lane;
   end
   assign out_push = xn_valid && (pk_idx == LIW'(LANES - 1));

   wms_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH)) u_ofifo (
      .clk(clk), .rst(rst), .push(out_push), .din(pk_next),
      .pop(gnt[SLOT_WX]), .dout(out_head), .count(out_cnt),
      .full(out_full), .empty(out_empty)
   );
   assign elig[SLOT_WX] = !rst && !out_empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         pk_idx  <= '0;
         pk_word <= '0;
      end else if (xn_valid) begin
         pk_word <= pk_next;
         pk_idx  <= (pk_idx == LIW'(LANES - 1)) ? '0 : pk_idx + 1'b1;
      end
   end

   // ---------------- memory port ----------------
   assign mem_re    = gnt[SLOT_RX] | gnt[SLOT_RF];
   assign mem_we    = gnt[SLOT_WX];
   assign mem_wdata = out_head;
   assign mem_addr  = gnt[SLOT_RX] ? rd_addr[0] :
                      gnt[SLOT_RF] ? rd_addr[1] : wr_addr;

   // ---------------- engine side ----------------
   assign calc_en = !rst && !sleep_req && !in_empty[0] && !in_empty[1] &&
                    !out_full && (int'(out_cnt) < OUT_DEPTH - HEADROOM);
   assign x_lane  = in_head[0][int'(li)*LANE_W +: LANE_W];
   assign f_lane  = in_head[1][int'(li)*LANE_W +: LANE_W];

   always_ff @(posedge clk) begin
      if (rst)          li <= '0;
      else if (calc_en) li <= (li == LIW'(LANES - 1)) ? '0 : li + 1'b1;
   end

   // ---------------- frame completion ----------------
   logic [FCW-1:0] fcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         fcnt      <= '0;
         frame_irq <= 1'b0;
      end else begin
         frame_irq <= 1'b0;
         if (xn_valid) begin
            if (fcnt == FCW'(FRAME_PAIRS - 1)) begin
               fcnt      <= '0;
               frame_irq <= 1'b1;
            end else begin
               fcnt <= fcnt + 1'b1;
            end
         end
      end
   end

   // R4
   port_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_re && mem_we));
   // R7
   lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!calc_en && !in_empty[0] && !in_empty[1]) |=> $stable(x_lane) && $stable(f_lane));
   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_irq && FRAME_PAIRS > 1) |=> !frame_irq);
   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      rst |-> !mem_re && !mem_we && !calc_en);
endmodule

// File: tb/sim_wide_mem_streamer.sv
`timescale 1ns/1ps
module sim_wide_mem_streamer;
   localparam int LANE_W = 24, WORD_W = 72, ADDR_W = 8, FW = 8;
   localparam int XB = 0, FB = 64, WB = 128;
   localparam int LANES = WORD_W / LANE_W;
   localparam int FP = FW * LANES;
   localparam int LAT = 3;
   localparam int RUN_CYCLES = 4000;

   logic clk = 1'b0, rst = 1'b1;
   logic [ADDR_W-1:0] mem_addr;
   logic mem_re, mem_we, calc_en, xn_valid, sleep_req, frame_irq;
   logic [WORD_W-1:0] mem_wdata, mem_rdata;
   logic [LANE_W-1:0] x_lane, f_lane, xn_lane;

   always #2.5 clk = ~clk;

   wide_mem_streamer #(
      .LANE_W(LANE_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .FRAME_WORDS(FW),
      .X_BASE(XB), .F_BASE(FB), .W_BASE(WB), .IN_DEPTH(4), .OUT_DEPTH(4), .HEADROOM(2)
   ) u0 (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .x_lane(x_lane), .f_lane(f_lane),
      .calc_en(calc_en), .xn_valid(xn_valid), .xn_lane(xn_lane),
      .sleep_req(sleep_req), .frame_irq(frame_irq)
   );

   // memory model: one-cycle read latency
   logic [WORD_W-1:0] mem [1 << ADDR_W];
   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] <= mem_wdata;
   end

   int total = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act,
                      input logic [WORD_W-1:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [11:0] elem(input int sel, input int idx);
      return 12'((idx * 113 + sel * 719 + 5) ^ (idx >> 2));
   endfunction
   function automatic logic [LANE_W-1:0] xpair(input int p);
      return {elem(1, 2*p+1), elem(1, 2*p)};
   endfunction
   function automatic logic [LANE_W-1:0] fpair(input int p);
      return {elem(2, 2*p+1), elem(2, 2*p)};
   endfunction
   function automatic logic [LANE_W-1:0] respair(input int c);
      logic [LANE_W-1:0] x, f;
      x = xpair(c % FP);
      f = fpair(c % FP);
      return {x[23:12] - f[23:12], x[11:0] + f[11:0]};
   endfunction
   function automatic logic [WORD_W-1:0] resword(input int w);
      logic [WORD_W-1:0] r;
      for (int j = 0; j < LANES; j++) r[j*LANE_W +: LANE_W] = respair(w*LANES + j);
      return r;
   endfunction

   // watchdog
   initial begin
      #(5.0 * 200000);
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic       pv [LAT];
      int         pc [LAT];
      int consumed = 0, produced = 0, rx = 0, rf = 0, wx = 0, acc = 0;
      int irqs = 0, sleep_left = 0, sleep_consumed = 0;
      bit irq_due = 0;
      void'($urandom(32'h5eed_0042));
      for (int k = 0; k < FW; k++) begin
         logic [WORD_W-1:0] xw, fw;
         for (int j = 0; j < LANES; j++) begin
            xw[j*LANE_W +: LANE_W] = xpair(k*LANES + j);
            fw[j*LANE_W +: LANE_W] = fpair(k*LANES + j);
         end
         mem[XB + k] = xw;
         mem[FB + k] = fw;
      end
      for (int i = 0; i < LAT; i++) begin pv[i] = 0; pc[i] = 0; end
      xn_valid = 0; xn_lane = '0; sleep_req = 0;

      // R10: quiet during reset
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); #1;
         chk(!mem_re && !mem_we && !calc_en && !frame_irq, "R10",
             {mem_re, mem_we, calc_en, frame_irq}, 0);
      end
      @(negedge clk); rst = 0;

      for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
         bit will_irq;
         if (cyc != 0) @(negedge clk);
         // engine result out
         will_irq = 0;
         xn_valid = pv[LAT-1];
         xn_lane  = pv[LAT-1] ? respair(pc[LAT-1]) : '0;
         if (pv[LAT-1]) begin
            produced++;
            will_irq = (produced % FP == 0);
         end
         for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; pc[i] = pc[i-1]; end
         // sleep stimulus: random bursts plus one long directed interval
         if (cyc == 1500) sleep_left = 20;
         else if (sleep_left == 0 && cyc > 40 && ($urandom % 16) == 0)
            sleep_left = 1 + ($urandom % 5);
         sleep_req = (sleep_left > 0);
         if (sleep_left > 0) sleep_left--;
         #1;
         // R8: interrupt one cycle after the frame's last result pair
         chk(frame_irq == irq_due, "R8", frame_irq, irq_due);
         if (frame_irq) irqs++;
         irq_due = will_irq;
         // R4 exclusive strobes
         chk(!(mem_re && mem_we), "R4", {mem_re, mem_we}, 0);
         // R6 sleep gates calc_en
         if (sleep_req) chk(!calc_en, "R6", calc_en, 0);
         if (cyc >= 1500 && cyc < 1520 && calc_en) sleep_consumed++;
         // memory access order and addresses
         if (mem_re || mem_we) begin
            acc++;
            if (acc <= 4) begin
               logic [ADDR_W-1:0] ea;
               ea = ADDR_W'((acc % 2 == 1) ? XB + (acc-1)/2 : FB + (acc-1)/2);
               // R5 start-up alternation
               chk(mem_re && mem_addr == ea, "R5", mem_addr, ea);
            end
         end
         if (mem_re) begin
            if (int'(mem_addr) < FB) begin
               chk(mem_addr == ADDR_W'(XB + rx % FW), "R2 R3 node read", mem_addr, XB + rx % FW);
               rx++;
            end else begin
               chk(mem_addr == ADDR_W'(FB + rf % FW), "R2 R3 speed read", mem_addr, FB + rf % FW);
               rf++;
            end
         end
         if (mem_we) begin
            chk(mem_addr == ADDR_W'(WB + wx % FW), "R2 R3 write addr", mem_addr, WB + wx % FW);
            chk(mem_wdata == resword(wx), "R1 write packing", mem_wdata, resword(wx));
            wx++;
         end
         // engine consumption: R1 lane order, R7/R9 sequence without loss
         if (calc_en) begin
            chk(x_lane == xpair(consumed % FP), "R1 R7 R9 node lane", x_lane, xpair(consumed % FP));
            chk(f_lane == fpair(consumed % FP), "R1 R7 R9 speed lane", f_lane, fpair(consumed % FP));
            pc[0] = consumed;
            consumed++;
         end
         pv[0] = calc_en;
      end

      // drain
      @(negedge clk); sleep_req = 1; xn_valid = 0;
      for (int i = 0; i < LAT; i++) begin
         @(negedge clk);
         xn_valid = pv[LAT-1]; xn_lane = pv[LAT-1] ? respair(pc[LAT-1]) : '0;
         if (pv[LAT-1]) produced++;
         for (int k = LAT-1; k > 0; k--) begin pv[k] = pv[k-1]; pc[k] = pc[k-1]; end
         pv[0] = 0;
      end
      @(negedge clk); xn_valid = 0;

      chk(sleep_consumed == 0, "R9 long sleep holds engine", sleep_consumed, 0);
      chk(consumed > 10 * FP, "R7 progress", consumed, 10 * FP);
      chk(wx > 5 * FW, "R2 writes issued", wx, 5 * FW);
      chk(irqs >= 10, "R8 interrupt count", irqs, 10);
      chk(rx >= consumed / LANES && rf >= consumed / LANES, "R4 reads cover consumption",
          rx, consumed / LANES);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule